// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block keeps the transmit and receive error counters of a CAN controller and derives the node's fault confinement state from them. A protocol engine drives single-cycle event pulses into it. These pulses report a transmit error, a transmit acknowledge error, a receive error, a good transmission and a good reception. The block answers with both 8-bit counters, a packed 32-bit read word, a fault-state code, two warning flags and a one-cycle pulse when the node goes bus off.

Two rules keep a node from leaving the bus for the wrong reason. The receive counter stops rising once it has passed 127. The next good reception drops it back to 127. Acknowledge errors stop raising the transmit counter once the node is error passive. Because of this, a node that is alone on the bus and never gets an acknowledge cannot reach bus off. Once bus off, the counters stay frozen until a controller reset or a block reset clears them.

Top module: `can_fault_counters`

## Requirements
- R1: After reset, both counters, the fault state and all flags are zero. The read word carries zero in its upper 16 bits, the receive counter in bits 15:8 and the transmit counter in bits 7:0.
- R2: A transmit error pulse adds 8 to the transmit counter. A good transmission pulse subtracts 1, and the counter never goes below 0. When both pulses arrive in the same cycle, the error wins.
- R3: A receive error pulse adds 1 to the receive counter while the counter is 127 or less. When the counter is above 127, a receive error leaves it unchanged.
- R4: A good reception while the receive counter is above 127 loads the counter with 127. At 127 or below, a good reception subtracts 1, and the counter never goes below 0. A receive error in the same cycle wins.
- R5: A transmit acknowledge error counts like a transmit error (+8) only while the state is error active. In error passive it leaves the transmit counter unchanged.
- R6: The fault-state code is 0 for error active, 1 for error passive and 2 for bus off. The state is error passive when either counter is 128 or more and the node is not bus off.
- R7: A counted transmit error that would raise the transmit counter above 255 moves the node to bus off. The transmit counter holds its value, and the bus-off pulse is high for exactly one cycle.
- R8: While bus off, no event pulse changes either counter.
- R9: The transmit warning flag is high when the transmit counter is 96 or more. The receive warning flag is high when the receive counter is 96 or more.
- R10: Events for the transmit counter and the receive counter in the same cycle update both counters in that cycle, independently of each other.
- R11: A controller reset pulse clears both counters and leaves bus off in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_reset | input | 1 | Synchronous controller reset pulse |
| ev_tx_err | input | 1 | Transmit error event |
| ev_tx_ack_err | input | 1 | Acknowledge error while transmitting |
| ev_rx_err | input | 1 | Receive error event |
| ev_tx_ok | input | 1 | Successful transmission event |
| ev_rx_ok | input | 1 | Successful reception event |
| tx_cnt | output | 8 | Transmit error counter |
| rx_cnt | output | 8 | Receive error counter |
| cnt_word | output | 32 | Read word: zero, receive counter, transmit counter |
| fault_state | output | 2 | 0 active, 1 passive, 2 bus off |
| tx_warn | output | 1 | Transmit counter at 96 or more |
| rx_warn | output | 1 | Receive counter at 96 or more |
| bus_off_pulse | output | 1 | One-cycle pulse on entry to bus off |

## Verification
The hardest situations to reach are the receive counter above 127 and the entry into bus off. Above 127, the stuck-counter and reload-to-127 rules apply. Bus off is entered from a transmit counter of 248 or more. Neither can be loaded directly. The bench therefore climbs there with long runs of single error pulses: 128 receive errors, then 31 transmit errors. Along the way it checks each threshold crossing, including the warning at 96 and error passive at 128. Acknowledge errors are tried both before and after the passive threshold, so the same pulse is seen counted and then ignored.

// File: rtl/can_fault_counters.sv
module can_fault_counters #(
  parameter int CW          = 8,
  parameter int TX_STEP     = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int WARN_LIM    = 96,
  parameter int RX_RELOAD   = 127
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_reset,
  input  logic          ev_tx_err,
  input  logic          ev_tx_ack_err,
  input  logic          ev_rx_err,
  input  logic          ev_tx_ok,
  input  logic          ev_rx_ok,
  output logic [CW-1:0] tx_cnt,
  output logic [CW-1:0] rx_cnt,
  output logic [31:0]   cnt_word,
  output logic [1:0]    fault_state,
  output logic          tx_warn,
  output logic          rx_warn,
  output logic          bus_off_pulse
);
  localparam logic [1:0] ST_ACTIVE  = 2'd0;
  localparam logic [1:0] ST_PASSIVE = 2'd1;
  localparam logic [1:0] ST_BUSOFF  = 2'd2;
  localparam int         PAD        = 32 - 2*CW;

  logic [CW-1:0] tx_q, rx_q, tx_d, rx_d;
  logic          off_q, off_d, pulse_q;
  logic [CW:0]   tx_sum;
  logic          passive, tx_hit, tx_over;

  assign passive = (int'(tx_q) >= PASSIVE_LIM) || (int'(rx_q) >= PASSIVE_LIM);
  assign tx_hit  = ev_tx_err || (ev_tx_ack_err && !passive);
  assign tx_sum  = {1'b0, tx_q} + (CW+1)'(TX_STEP);
  assign tx_over = tx_sum[CW];

  always_comb begin
    tx_d  = tx_q;
    off_d = off_q;
    if (tx_hit) begin
      if (tx_over) off_d = 1'b1;
      else         tx_d  = tx_sum[CW-1:0];
    end else if (ev_tx_ok && tx_q != '0) begin
      tx_d = tx_q - 1'b1;
    end
  end

  always_comb begin
    rx_d = rx_q;
    if (ev_rx_err) begin
      if (int'(rx_q) < PASSIVE_LIM) rx_d = rx_q + 1'b1;
    end else if (ev_rx_ok) begin
      if (int'(rx_q) >= PASSIVE_LIM) rx_d = CW'(RX_RELOAD);
      else if (rx_q != '0)           rx_d = rx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_q    <= '0;
      off_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (ctl_reset) begin
      tx_q    <= '0;
      rx_q    <= '0;
      off_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (!off_q) begin
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      off_q   <= off_d;
      pulse_q <= off_d;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign tx_cnt        = tx_q;
  assign rx_cnt        = rx_q;
  assign cnt_word      = {{PAD{1'b0}}, rx_q, tx_q};
  assign fault_state   = off_q ? ST_BUSOFF : (passive ? ST_PASSIVE : ST_ACTIVE);
  assign tx_warn       = int'(tx_q) >= WARN_LIM;
  assign rx_warn       = int'(rx_q) >= WARN_LIM;
  assign bus_off_pulse = pulse_q;
endmodule

// File: rtl/can_fault_counters_chk.sv
module can_fault_counters_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_reset,
  input logic       ev_tx_err,
  input logic       ev_tx_ack_err,
  input logic       ev_rx_err,
  input logic       ev_tx_ok,
  input logic       ev_rx_ok,
  input logic [7:0] tx_cnt,
  input logic [7:0] rx_cnt,
  input logic [1:0] fault_state,
  input logic       bus_off_pulse
);
  p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt > 8'd127 && ev_rx_err && fault_state != 2'd2 && !ctl_reset) |=> rx_cnt == $past(rx_cnt));

  p_rx_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt > 8'd127 && ev_rx_ok && !ev_rx_err && fault_state != 2'd2 && !ctl_reset) |=> rx_cnt == 8'd127);

  p_ack_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_state == 2'd1 && ev_tx_ack_err && !ev_tx_err && !ev_tx_ok && !ctl_reset) |=> tx_cnt == $past(tx_cnt));

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off_pulse |=> !bus_off_pulse);

  p_pulse_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off_pulse |-> fault_state == 2'd2);

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_state == 2'd2 && !ctl_reset) |=> ($stable(tx_cnt) && $stable(rx_cnt)));

  p_ctl_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> (tx_cnt == 8'd0 && rx_cnt == 8'd0 && fault_state == 2'd0));
endmodule

bind can_fault_counters can_fault_counters_chk chk_i (.*);

// File: tb/can_fault_counters_tb_top.sv
module can_fault_counters_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, ctl_reset = 1'b0;
  logic ev_tx_err = 0, ev_tx_ack_err = 0, ev_rx_err = 0, ev_tx_ok = 0, ev_rx_ok = 0;
  logic [7:0]  tx_cnt, rx_cnt;
  logic [31:0] cnt_word;
  logic [1:0]  fault_state;
  logic        tx_warn, rx_warn, bus_off_pulse;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fault_counters dut_i (.*);

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ev(bit te, bit ae, bit re, bit to, bit ro, bit cr = 0);
    @(negedge clk);
    ev_tx_err = te; ev_tx_ack_err = ae; ev_rx_err = re;
    ev_tx_ok = to; ev_rx_ok = ro; ctl_reset = cr;
    @(negedge clk);
    ev_tx_err = 0; ev_tx_ack_err = 0; ev_rx_err = 0;
    ev_tx_ok = 0; ev_rx_ok = 0; ctl_reset = 0;
  endtask

  task automatic clear();
    ev(0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_reset();
    chk("R1 tx", tx_cnt, 0);
    chk("R1 rx", rx_cnt, 0);
    chk("R1 word", cnt_word, 0);
    chk("R1 state", fault_state, 0);
    chk("R1 flags", {tx_warn, rx_warn, bus_off_pulse}, 0);
  endtask

  task automatic t_tx_basic();
    clear();
    ev(0, 0, 0, 1, 0); chk("R2 floor", tx_cnt, 0);
    for (int i = 0; i < 3; i++) ev(1, 0, 0, 0, 0);
    chk("R2 add8", tx_cnt, 24);
    ev(0, 0, 0, 1, 0); chk("R2 dec", tx_cnt, 23);
    ev(1, 0, 0, 1, 0); chk("R2 err wins", tx_cnt, 31);
    ev(0, 0, 1, 0, 0); ev(0, 0, 1, 0, 0);
    chk("R1 word layout", cnt_word, 32'h0000_021F);
  endtask

  task automatic t_both();
    clear();
    ev(1, 0, 1, 0, 0);
    chk("R10 tx", tx_cnt, 8); chk("R10 rx", rx_cnt, 1);
    ev(0, 0, 0, 1, 1);
    chk("R10 tx dec", tx_cnt, 7); chk("R10 rx dec", rx_cnt, 0);
    ev(0, 0, 0, 0, 1); chk("R4 floor", rx_cnt, 0);
  endtask

  task automatic t_rx_limit();
    clear();
    for (int i = 0; i < 95; i++) ev(0, 0, 1, 0, 0);
    chk("R9 rx below", rx_warn, 0);
    ev(0, 0, 1, 0, 0);
    chk("R9 rx warn", rx_warn, 1);
    for (int i = 0; i < 31; i++) ev(0, 0, 1, 0, 0);
    chk("R3 at127", rx_cnt, 127); chk("R6 active", fault_state, 0);
    ev(0, 0, 1, 0, 0);
    chk("R3 at128", rx_cnt, 128); chk("R6 passive", fault_state, 1);
    ev(0, 0, 1, 0, 0); chk("R3 hold", rx_cnt, 128);
    ev(0, 0, 1, 0, 1); chk("R4 err wins", rx_cnt, 128);
    ev(0, 0, 0, 0, 1); chk("R4 reload", rx_cnt, 127);
    chk("R6 back active", fault_state, 0);
    ev(0, 0, 0, 0, 1); chk("R4 dec", rx_cnt, 126);
  endtask

  task automatic t_ack();
    clear();
    ev(0, 1, 0, 0, 0); chk("R5 counted active", tx_cnt, 8);
    for (int i = 0; i < 11; i++) ev(1, 0, 0, 0, 0);
    chk("R9 tx warn", tx_warn, 1);
    for (int i = 0; i < 4; i++) ev(1, 0, 0, 0, 0);
    chk("R6 tx passive", fault_state, 1);
    ev(0, 1, 0, 0, 0); chk("R5 ignored passive", tx_cnt, 128);
  endtask

  task automatic t_busoff();
    for (int i = 0; i < 15; i++) ev(1, 0, 0, 0, 0);
    chk("R7 pre", tx_cnt, 248); chk("R7 pre state", fault_state, 1);
    ev(0, 0, 1, 0, 0);
    ev(1, 0, 0, 0, 0);
    chk("R7 pulse", bus_off_pulse, 1);
    chk("R7 held", tx_cnt, 248);
    chk("R6 busoff", fault_state, 2);
    ev(1, 0, 1, 1, 1);
    chk("R7 pulse once", bus_off_pulse, 0);
    chk("R8 tx frozen", tx_cnt, 248); chk("R8 rx frozen", rx_cnt, 1);
    clear();
    chk("R11 tx", tx_cnt, 0); chk("R11 rx", rx_cnt, 0);
    chk("R11 state", fault_state, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_basic();
    t_both();
    t_rx_limit();
    t_ack();
    t_busoff();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule